// File: doc/BRIEF.md
# I2C Slave Address and Extension-Code Detector

This block sits on the receive side of an I2C slave port and looks only at the first byte that follows a START condition. The SCL and SDA lines pass through a chain of synchroniser flip-flops. START and STOP conditions and the SCL edges are then found in the system clock domain. The seven address bits and the R/W bit are shifted in on SCL rising edges. After the eighth falling edge, the byte is compared with a locally held slave address.

The comparison produces several status flags:

- an address-match flag
- an extension-code flag, set for any byte whose top four bits are all zeros or all ones
- a general-call flag
- the received direction bit
- a "taking part" flag

A single-cycle interrupt pulse goes out whenever the slave is taking part, which happens on an address match or on an extension code. A 10-bit header byte that equals a local address of the form 11110xx0 sets both the match flag and the extension flag. Software reads the direction bit to tell a 10-bit write header from a 10-bit read header.

Software can pulse a release input to leave the current transfer. The block then stays in standby and ignores the bus until a new START appears.

Top module: `i2c_addr_detect`

## Requirements
- R1: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) clears status bits 5..1. This includes a repeated START in the middle of a transfer.
- R2: Status bit 5 (extension) is 1 after the address byte exactly when the received bits [7:4] are 4'b0000 or 4'b1111.
- R3: Status bit 4 (match) is 1 after the address byte exactly when the received bits [7:1] equal the local address bits [7:1]. A local address 8'b11110xx0 with the same received byte sets bits 5 and 4 together.
- R4: Status bit 3 (general call) is 1 exactly when the received byte is 8'h00.
- R5: Status bit 2 holds the received R/W bit (bit 0 of the byte). This tells a 11110xx header with R/W=0 apart from one with R/W=1.
- R6: Status bit 1 (taking part) equals bit 5 OR bit 4. irq_o pulses for exactly one clock per address byte, and only when bit 1 gets set.
- R7: No status flag and no interrupt appears before the falling SCL edge of the 8th bit. Both appear within a few system clocks after that edge.
- R8: The local address register loads addr_wdata when addr_we is high and is read back on addr_o. Receiving an extension code never changes it.
- R9: A pulse on release_i clears bit 1 and sets bit 0 (standby). In standby, SCL edges and STOP are ignored and no flag or interrupt is raised. The next START clears bit 0.
- R10: After reset, status_o is 0, irq_o is 0 and addr_o equals RESET_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| addr_we | input | 1 | Write strobe for the local address register |
| addr_wdata | input | BYTE_W | New local address value |
| addr_o | output | BYTE_W | Current local address register |
| release_i | input | 1 | One-cycle request to drop out of the transfer |
| status_o | output | 8 | Bit5 extension, bit4 match, bit3 general call, bit2 R/W, bit1 taking part, bit0 standby |
| irq_o | output | 1 | One-cycle interrupt after a byte that selects the slave |

## Verification
Each fault in the internal state shows up at the ports in its own way:

- A bit counter that is off by one makes the flags and the interrupt appear one SCL bit early or late. This is visible at the check made just before the 8th falling edge.
- A wrong shift order or a wrong compare corrupts bits 5..2 for some of the 256 byte values. A full sweep of all 256 values against two local addresses exposes this within one byte time.
- A standby state that leaks, or START/STOP detection that fails, leaves stale flags after the bus condition. This is visible a few clocks after the STOP or the release.

// File: rtl/i2c_ad_pkg.sv
package i2c_ad_pkg;
   localparam int STAT_W   = 8;
   localparam int ST_EXT   = 5;
   localparam int ST_MATCH = 4;
   localparam int ST_GCALL = 3;
   localparam int ST_RW    = 2;
   localparam int ST_SEL   = 1;
   localparam int ST_STBY  = 0;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_HOLD = 2'd2,
      PH_STBY = 2'd3
   } phase_t;
endpackage

// File: rtl/i2c_ad_sync.sv
module i2c_ad_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_ad_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   // Lines idle high, so the chain resets to ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_ad_cond.sv
module i2c_ad_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   // SDA may only move on a stable high SCL for a bus condition.
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ad_shift.sv
module i2c_ad_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              enable,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   output logic [BYTE_W-1:0] byte_o,
   output logic              done
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sreg <= '0;
      end else if (clear) begin
         cnt  <= '0;
      end else if (enable && scl_rise && cnt != LAST) begin
         sreg <= {sreg[BYTE_W-2:0], sda_s};
         cnt  <= cnt + 1'b1;
      end
   end

   assign byte_o = sreg;
   // Byte is complete at the falling SCL edge that closes the last bit.
   assign done   = enable & scl_fall & (cnt == LAST);
endmodule

// File: rtl/i2c_ad_match.sv
module i2c_ad_match #(
   parameter int BYTE_W = 8,
   parameter int HDR_W  = 4
) (
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [BYTE_W-1:0] own_addr,
   output logic              ext_hit,
   output logic              addr_hit,
   output logic              gcall_hit
);
   if (HDR_W < 1 || HDR_W > BYTE_W - 1) begin : g_bad_hdr
      $error("i2c_ad_match: HDR_W out of range");
   end

   logic [HDR_W-1:0] head;
   assign head      = rx_byte[BYTE_W-1 -: HDR_W];
   assign ext_hit   = (head == '0) || (head == '1);
   assign addr_hit  = rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-1:1];
   assign gcall_hit = rx_byte == '0;
endmodule

// File: rtl/i2c_addr_detect.sv
module i2c_addr_detect
   import i2c_ad_pkg::*;
#(
   parameter int          SYNC_STAGES = 2,
   parameter int          BYTE_W      = 8,
   parameter int          HDR_W       = 4,
   parameter logic [7:0]  RESET_ADDR  = 8'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              addr_we,
   input  logic [BYTE_W-1:0] addr_wdata,
   output logic [BYTE_W-1:0] addr_o,
   input  logic              release_i,
   output logic [STAT_W-1:0] status_o,
   output logic              irq_o
);
   if (BYTE_W != 8) begin : g_bad_width
      $error("i2c_addr_detect: BYTE_W must be 8 for an I2C address byte");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;
   logic [BYTE_W-1:0] rx_byte;
   logic done, ext_hit, addr_hit, gcall_hit;

   phase_t phase;
   logic [BYTE_W-1:0] own_q;
   logic f_ext, f_match, f_gcall, f_rw, f_sel, irq_q;

   i2c_ad_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
   );

   i2c_ad_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_ad_shift #(.BYTE_W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .clear(start_det | release_i),
      .enable(phase == PH_ADDR),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
      .byte_o(rx_byte), .done(done)
   );

   i2c_ad_match #(.BYTE_W(BYTE_W), .HDR_W(HDR_W)) u_match (
      .rx_byte(rx_byte), .own_addr(own_q),
      .ext_hit(ext_hit), .addr_hit(addr_hit), .gcall_hit(gcall_hit)
   );

   // Local address register: only software writes it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       own_q <= BYTE_W'(RESET_ADDR);
      else if (addr_we) own_q <= addr_wdata;
   end

   // Phase and flags. Priority: release, START, STOP, byte done.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         f_ext   <= 1'b0;
         f_match <= 1'b0;
         f_gcall <= 1'b0;
         f_rw    <= 1'b0;
         f_sel   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (release_i) begin
            phase <= PH_STBY;
            f_sel <= 1'b0;
         end else if (start_det) begin
            phase   <= PH_ADDR;
            f_ext   <= 1'b0;
            f_match <= 1'b0;
            f_gcall <= 1'b0;
            f_rw    <= 1'b0;
            f_sel   <= 1'b0;
         end else if (stop_det) begin
            if (phase != PH_STBY) phase <= PH_IDLE;
            f_ext   <= 1'b0;
            f_match <= 1'b0;
            f_gcall <= 1'b0;
            f_rw    <= 1'b0;
            f_sel   <= 1'b0;
         end else if (done) begin
            phase   <= PH_HOLD;
            f_ext   <= ext_hit;
            f_match <= addr_hit;
            f_gcall <= gcall_hit;
            f_rw    <= rx_byte[0];
            f_sel   <= ext_hit | addr_hit;
            irq_q   <= ext_hit | addr_hit;
         end
      end
   end

   always_comb begin
      status_o           = '0;
      status_o[ST_EXT]   = f_ext;
      status_o[ST_MATCH] = f_match;
      status_o[ST_GCALL] = f_gcall;
      status_o[ST_RW]    = f_rw;
      status_o[ST_SEL]   = f_sel;
      status_o[ST_STBY]  = phase == PH_STBY;
   end

   assign irq_o  = irq_q;
   assign addr_o = own_q;
endmodule

// File: rtl/i2c_ad_chk.sv
module i2c_ad_chk
   import i2c_ad_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_we,
   input logic [BYTE_W-1:0] addr_o,
   input logic [STAT_W-1:0] status_o,
   input logic              irq_o
);
   // R6
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
   // R6
   irq_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> status_o[ST_SEL]);
   // R6
   sel_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[ST_SEL]) |-> irq_o);
   // R4
   gcall_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[ST_GCALL] |-> status_o[ST_EXT]);
   // R9
   stby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[ST_STBY] |=> !$rose(status_o[ST_EXT]) && !irq_o);
   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_we |=> $stable(addr_o));
endmodule

bind i2c_addr_detect i2c_ad_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_o(addr_o),
   .status_o(status_o), .irq_o(irq_o)
);

// File: tb/test_i2c_addr_detect.sv
module test_i2c_addr_detect;
   localparam int HP = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1;
   logic addr_we = 1'b0;
   logic [7:0] addr_wdata = '0;
   logic [7:0] addr_o;
   logic release_i = 1'b0;
   logic [7:0] status_o;
   logic irq_o;

   int errors = 0, checks = 0, irq_cnt = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   i2c_addr_detect i_i2c_addr_detect (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .addr_we(addr_we), .addr_wdata(addr_wdata), .addr_o(addr_o),
      .release_i(release_i), .status_o(status_o), .irq_o(irq_o)
   );

   always @(posedge clk) if (irq_o) irq_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hp(); repeat (HP) @(negedge clk); endtask

   task automatic do_start(); sda = 1; hp(); scl = 1; hp(); sda = 0; hp(); scl = 0; hp(); endtask
   task automatic do_stop();  sda = 0; hp(); scl = 1; hp(); sda = 1; hp(); endtask
   task automatic clk_bit(input logic v); sda = v; hp(); scl = 1; hp(); scl = 0; hp(); endtask

   task automatic set_addr(input logic [7:0] a);
      @(negedge clk); addr_wdata = a; addr_we = 1;
      @(negedge clk); addr_we = 0;
   endtask

   task automatic pulse_release();
      @(negedge clk); release_i = 1;
      @(negedge clk); release_i = 0; hp();
   endtask

   function automatic logic [7:0] exp_stat(input logic [7:0] b, input logic [7:0] own);
      logic e, m;
      e = (b[7:4] == 4'h0) || (b[7:4] == 4'hF);
      m = b[7:1] == own[7:1];
      return {2'b00, e, m, (b == 8'h00), b[0], (e | m), 1'b0};
   endfunction

   // Sends the 8 bits with a check just before the 8th falling edge (R7).
   task automatic send_byte(input logic [7:0] b, input int base_irq);
      for (int i = 7; i >= 1; i--) clk_bit(b[i]);
      sda = b[0]; hp(); scl = 1; hp();
      chk("R7 no flags before 8th fall", int'(status_o), 0);
      chk("R7 no irq before 8th fall", irq_cnt - base_irq, 0);
      scl = 0; hp();
   endtask

   task automatic xfer(input logic [7:0] b, input logic [7:0] own);
      int base;
      logic [7:0] e;
      e = exp_stat(b, own);
      do_start();
      base = irq_cnt;
      send_byte(b, base);
      // R2 R3 R4 R5 R6: whole status vector after the address byte
      chk($sformatf("R2/R3/R4/R5 status byte=%02h own=%02h", b, own), int'(status_o), int'(e));
      chk("R6 irq count", irq_cnt - base, int'(e[1]));
      do_stop();
      chk("R1 clear on STOP", int'(status_o), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10
      chk("R10 reset status", int'(status_o), 0);
      chk("R10 reset irq", int'(irq_o), 0);
      chk("R10 reset addr", int'(addr_o), 8'hA0);

      // R8 write and read back
      set_addr(8'hB4);
      chk("R8 addr readback", int'(addr_o), 8'hB4);

      // Exhaustive sweep against two local addresses
      for (int o = 0; o < 2; o++) begin
         logic [7:0] own;
         own = (o == 0) ? 8'hB4 : 8'hF2;
         set_addr(own);
         for (int b = 0; b < 256; b++) xfer(8'(b), own);
      end

      // R3 10-bit header equal to local address sets extension and match; R8 unchanged
      set_addr(8'hF2);
      xfer(8'hF2, 8'hF2);
      chk("R8 addr after extension code", int'(addr_o), 8'hF2);
      // R5 read header
      do_start(); send_byte(8'hF3, irq_cnt);
      chk("R5 read header rw bit", int'(status_o), 8'h36);
      // R1 repeated start clears flags
      sda = 1; hp(); scl = 1; hp(); sda = 0; hp();
      chk("R1 clear on repeated START", int'(status_o), 0);
      scl = 0; hp();
      send_byte(8'hF2, irq_cnt);
      chk("R3 after repeated START", int'(status_o), 8'h32);
      do_stop();

      // R9 release mid-byte, then ignored bits and STOP
      set_addr(8'hB4);
      begin
         int base;
         do_start();
         base = irq_cnt;
         clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
         pulse_release();
         chk("R9 standby after release", int'(status_o), 8'h01);
         clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b0);
         hp();
         chk("R9 bits ignored in standby", int'(status_o), 8'h01);
         chk("R9 no irq in standby", irq_cnt - base, 0);
         do_stop();
         chk("R9 STOP keeps standby", int'(status_o), 8'h01);
         do_start();
         chk("R9 START leaves standby", int'(status_o), 0);
         base = irq_cnt;
         send_byte(8'hB4, base);
         chk("R9 match after standby", int'(status_o), 8'h12);
         chk("R6 irq after standby", irq_cnt - base, 1);
         do_stop();
      end

      // R9 release after extension code drops taking-part bit
      do_start(); send_byte(8'hF0, irq_cnt);
      chk("R2 extension before release", int'(status_o), 8'h22);
      pulse_release();
      chk("R9 release clears taking part", int'(status_o), 8'h21);
      do_stop();
      chk("R1 STOP in standby clears flags", int'(status_o), 8'h01);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule